// File: doc/BRIEF.md
# Multi-Mode Uplink Load Modulator

This block shapes the load-modulation line with which a transponder answers a reader. A frame begins on a one-cycle start strobe. It carries a coding mode, a start-of-frame length, a bit count and a left-aligned data word. The block then drives the line through three parts in order: a constant-high lead-in, the start-of-frame symbols, and the data bits, most significant bit first. When the frame ends, the line returns low.

Four codings are available. Two are anticollision codings, where a zero is one long high/low pair and a one is two short pairs. The other two are Manchester codings, where a one is high-then-low and a zero is low-then-high. Each coding family has a slow and a fast rate. All symbol timing is counted in carrier periods, which arrive as a single-cycle `carrier_tick`. The level for carrier period k is visible from the clock after the k-th tick of the frame until the clock after the next tick.

Top module: `uplink_load_modulator`

## Requirements
- R1: During and directly after a synchronous active-low reset, `mod_out`, `busy` and `done` are all 0.
- R2: A start is accepted only while `busy` is 0. The mode, start-of-frame length, bit count and word are captured at acceptance. Later changes on these inputs, and starts while `busy` is 1, have no effect on the frame being sent.
- R3: The lead-in holds `mod_out` high for 20 carrier periods in modes 0 and 2, and for 40 carrier periods in modes 1 and 3.
- R4: With `sof_long` = 0 the start-of-frame is three one symbols. With `sof_long` = 1 it is one, one, one, zero.
- R5: Mode 0 (anticollision, slow) uses 64-period symbols. A zero is high for periods 0–31 and low for 32–63. A one is high for 0–15, low for 16–31, high for 32–47 and low for 48–63.
- R6: Mode 1 (anticollision, fast) uses 32-period symbols with every edge at half the mode 0 time.
- R7: Mode 2 (Manchester, slow) uses 32-period symbols. A one is high for periods 0–15 and low for 16–31. A zero is the reverse.
- R8: Mode 3 (Manchester, fast) uses 16-period symbols with 8-period halves and the same polarity as mode 2.
- R9: With bit count N, the data bits sent are word bits FRAME_W-1 down to FRAME_W-N. N = 0 sends no data bits. Any N above FRAME_W is treated as FRAME_W.
- R10: `mod_out` changes only on the clock edge that follows a cycle with `carrier_tick` = 1.
- R11: `busy` is 1 from the clock after acceptance through the last period of the last symbol. `done` is 1 for exactly the one cycle in which `busy` has just fallen. `mod_out` is 0 whenever `busy` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| carrier_tick | input | 1 | One-cycle pulse per carrier period |
| start | input | 1 | Begin a frame (accepted when idle) |
| mode | input | 2 | 0 slow anticollision, 1 fast anticollision, 2 slow Manchester, 3 fast Manchester |
| sof_long | input | 1 | 0: three-symbol start-of-frame, 1: four-symbol |
| bit_count | input | clog2(FRAME_W+1) | Number of data bits to send |
| frame_word | input | FRAME_W | Data, left-aligned, sent MSB first |
| mod_out | output | 1 | Load-modulation line |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-cycle pulse after the frame |

## Verification
The bench builds the block with FRAME_W = 16 and keeps the default symbol unit of 16 and lead-in lengths of 20 and 40. The narrow word means a bit count of 20 exercises the clamp to the word width. It also keeps the longest frame, slow anticollision with a full word, to a few thousand clocks. The carrier tick arrives on every other clock, so a level that moves without a tick, or that is counted in clocks instead of periods, shows up as a mismatch against the per-period expected waveform.

// File: rtl/ulm_pkg.sv
// Package: shared types and helpers for the uplink load modulator.
// Assumes: mode encoding is fixed by the top-level port definition.
package ulm_pkg;

    typedef enum logic [1:0] {
        MODE_AC_SLOW = 2'd0,
        MODE_AC_FAST = 2'd1,
        MODE_MC_SLOW = 2'd2,
        MODE_MC_FAST = 2'd3
    } ulm_mode_e;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_LEAD = 2'd1,
        PH_SOF  = 2'd2,
        PH_DATA = 2'd3
    } ulm_phase_e;

    // True for the two double-rate codings
    function automatic logic mode_is_fast(ulm_mode_e m);
        return (m == MODE_AC_FAST) || (m == MODE_MC_FAST);
    endfunction

    // True for the two anticollision codings
    function automatic logic mode_is_ac(ulm_mode_e m);
        return (m == MODE_AC_SLOW) || (m == MODE_AC_FAST);
    endfunction

endpackage

// File: rtl/ulm_period_timer.sv
// Module: ulm_period_timer
// Counts carrier periods inside the current lead-in or symbol. It flags the
// tick that closes that span.
// Assumes: SLOW_UNIT is even; CW holds the longest span.
module ulm_period_timer
    import ulm_pkg::*;
#(
    parameter int SLOW_UNIT = 16,
    parameter int LEAD_SLOW = 20,
    parameter int LEAD_FAST = 40,
    parameter int CW        = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic             tick,
    input  ulm_phase_e       phase,
    input  ulm_mode_e        mode,
    output logic [CW-1:0]    pcnt,
    output logic             span_end
);

    localparam int FAST_UNIT = SLOW_UNIT / 2;
    localparam logic [CW-1:0] LAST_AC_SLOW = CW'(4 * SLOW_UNIT - 1);
    localparam logic [CW-1:0] LAST_AC_FAST = CW'(4 * FAST_UNIT - 1);
    localparam logic [CW-1:0] LAST_MC_SLOW = CW'(2 * SLOW_UNIT - 1);
    localparam logic [CW-1:0] LAST_MC_FAST = CW'(2 * FAST_UNIT - 1);
    localparam logic [CW-1:0] LAST_LD_SLOW = CW'(LEAD_SLOW - 1);
    localparam logic [CW-1:0] LAST_LD_FAST = CW'(LEAD_FAST - 1);

    logic [CW-1:0] last_period;

    // Select the index of the final period for the current phase and mode
    always_comb begin
        if (phase == PH_LEAD) begin
            last_period = mode_is_fast(mode) ? LAST_LD_FAST : LAST_LD_SLOW;
        end else begin
            unique case (mode)
                MODE_AC_SLOW: last_period = LAST_AC_SLOW;
                MODE_AC_FAST: last_period = LAST_AC_FAST;
                MODE_MC_SLOW: last_period = LAST_MC_SLOW;
                default:      last_period = LAST_MC_FAST;
            endcase
        end
    end

    assign span_end = tick && (phase != PH_IDLE) && (pcnt == last_period);

    // Period counter: cleared on frame start, wraps at each span end
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pcnt <= '0;
        end else if (restart) begin
            pcnt <= '0;
        end else if (tick && (phase != PH_IDLE)) begin
            pcnt <= span_end ? '0 : pcnt + 1'b1;
        end
    end

endmodule

// File: rtl/ulm_frame_seq.sv
// Module: ulm_frame_seq
// Frame sequencer. It captures the request, walks lead-in, start-of-frame and
// data, and supplies the symbol bit now being sent.
// Assumes: span_end marks the final period of the current span.
module ulm_frame_seq
    import ulm_pkg::*;
#(
    parameter int FRAME_W = 32,
    parameter int NW      = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [1:0]         mode_in,
    input  logic               sof_long_in,
    input  logic [NW-1:0]      nbits_in,
    input  logic [FRAME_W-1:0] word_in,
    input  logic               span_end,
    output logic               accept,
    output ulm_phase_e         phase,
    output ulm_mode_e          mode_q,
    output logic               cur_bit,
    output logic               busy,
    output logic               done
);

    localparam logic [NW-1:0] MAX_BITS = NW'(FRAME_W);

    logic               sof_long_q;
    logic [1:0]         sof_idx;
    logic [NW-1:0]      bits_q;
    logic [NW-1:0]      bit_idx;
    logic [FRAME_W-1:0] shreg;
    logic [NW-1:0]      n_eff;
    logic               sof_last;
    logic               data_last;

    assign accept    = start && (phase == PH_IDLE);
    assign busy      = (phase != PH_IDLE);
    assign n_eff     = (nbits_in > MAX_BITS) ? MAX_BITS : nbits_in;
    assign sof_last  = (sof_idx == (sof_long_q ? 2'd3 : 2'd2));
    assign data_last = (bit_idx == bits_q - 1'b1);

    // Bit of the symbol in progress: the fourth start-of-frame symbol is zero
    always_comb begin
        unique case (phase)
            PH_SOF:  cur_bit = !(sof_long_q && (sof_idx == 2'd3));
            PH_DATA: cur_bit = shreg[FRAME_W-1];
            default: cur_bit = 1'b1;
        endcase
    end

    // Phase walk, request capture and completion pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase      <= PH_IDLE;
            mode_q     <= MODE_AC_SLOW;
            sof_long_q <= 1'b0;
            sof_idx    <= '0;
            bits_q     <= '0;
            bit_idx    <= '0;
            shreg      <= '0;
            done       <= 1'b0;
        end else begin
            done <= 1'b0;
            if (accept) begin
                phase      <= PH_LEAD;
                mode_q     <= ulm_mode_e'(mode_in);
                sof_long_q <= sof_long_in;
                bits_q     <= n_eff;
                shreg      <= word_in;
                sof_idx    <= '0;
                bit_idx    <= '0;
            end else if (span_end) begin
                unique case (phase)
                    PH_LEAD: begin
                        phase   <= PH_SOF;
                        sof_idx <= '0;
                    end
                    PH_SOF: begin
                        if (!sof_last) begin
                            sof_idx <= sof_idx + 1'b1;
                        end else if (bits_q == '0) begin
                            phase <= PH_IDLE;
                            done  <= 1'b1;
                        end else begin
                            phase   <= PH_DATA;
                            bit_idx <= '0;
                        end
                    end
                    PH_DATA: begin
                        if (data_last) begin
                            phase <= PH_IDLE;
                            done  <= 1'b1;
                        end else begin
                            bit_idx <= bit_idx + 1'b1;
                            shreg   <= {shreg[FRAME_W-2:0], 1'b0};
                        end
                    end
                    default: phase <= PH_IDLE;
                endcase
            end
        end
    end

endmodule

// File: rtl/ulm_wave_shaper.sv
// Module: ulm_wave_shaper
// Maps phase, coding, bit and period index to the line level.
// Assumes: pcnt stays inside the current span.
module ulm_wave_shaper
    import ulm_pkg::*;
#(
    parameter int SLOW_UNIT = 16,
    parameter int CW        = 7
) (
    input  ulm_phase_e    phase,
    input  ulm_mode_e     mode,
    input  logic          sym_bit,
    input  logic [CW-1:0] pcnt,
    output logic          level
);

    localparam logic [CW-1:0] U1_SLOW = CW'(SLOW_UNIT);
    localparam logic [CW-1:0] U2_SLOW = CW'(2 * SLOW_UNIT);
    localparam logic [CW-1:0] U3_SLOW = CW'(3 * SLOW_UNIT);
    localparam logic [CW-1:0] U1_FAST = CW'(SLOW_UNIT / 2);
    localparam logic [CW-1:0] U2_FAST = CW'(SLOW_UNIT);
    localparam logic [CW-1:0] U3_FAST = CW'(3 * (SLOW_UNIT / 2));

    logic [CW-1:0] u1, u2, u3;
    logic          ac_level, mc_level;

    // Edge positions for the selected rate
    always_comb begin
        if (mode_is_fast(mode)) begin
            u1 = U1_FAST; u2 = U2_FAST; u3 = U3_FAST;
        end else begin
            u1 = U1_SLOW; u2 = U2_SLOW; u3 = U3_SLOW;
        end
    end

    // Symbol levels for both coding families
    always_comb begin
        ac_level = sym_bit ? ((pcnt < u1) || ((pcnt >= u2) && (pcnt < u3)))
                           : (pcnt < u2);
        mc_level = sym_bit ? (pcnt < u1) : (pcnt >= u1);
    end

    // Final level by phase
    always_comb begin
        unique case (phase)
            PH_IDLE: level = 1'b0;
            PH_LEAD: level = 1'b1;
            default: level = mode_is_ac(mode) ? ac_level : mc_level;
        endcase
    end

endmodule

// File: rtl/uplink_load_modulator.sv
// Module: uplink_load_modulator (top)
// Emits lead-in, start-of-frame and MSB-first data on one load-modulation
// line, in one of four codings, paced by a carrier-period tick.
// Assumes: carrier_tick is a single-cycle pulse; SLOW_UNIT is even.
module uplink_load_modulator
    import ulm_pkg::*;
#(
    parameter int FRAME_W   = 32,
    parameter int SLOW_UNIT = 16,
    parameter int LEAD_SLOW = 20,
    parameter int LEAD_FAST = 40
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         carrier_tick,
    input  logic                         start,
    input  logic [1:0]                   mode,
    input  logic                         sof_long,
    input  logic [$clog2(FRAME_W+1)-1:0] bit_count,
    input  logic [FRAME_W-1:0]           frame_word,
    output logic                         mod_out,
    output logic                         busy,
    output logic                         done
);

    localparam int NW       = $clog2(FRAME_W + 1);
    localparam int SPAN_A   = (4 * SLOW_UNIT > LEAD_FAST) ? 4 * SLOW_UNIT : LEAD_FAST;
    localparam int SPAN_MAX = (SPAN_A > LEAD_SLOW) ? SPAN_A : LEAD_SLOW;
    localparam int CW       = $clog2(SPAN_MAX + 1);

    logic          accept_w;
    logic          span_end_w;
    logic          bit_w;
    logic [CW-1:0] pcnt_w;
    ulm_phase_e    phase_w;
    ulm_mode_e     mode_w;

    ulm_frame_seq #(.FRAME_W(FRAME_W), .NW(NW)) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start),
        .mode_in     (mode),
        .sof_long_in (sof_long),
        .nbits_in    (bit_count),
        .word_in     (frame_word),
        .span_end    (span_end_w),
        .accept      (accept_w),
        .phase       (phase_w),
        .mode_q      (mode_w),
        .cur_bit     (bit_w),
        .busy        (busy),
        .done        (done)
    );

    ulm_period_timer #(
        .SLOW_UNIT (SLOW_UNIT),
        .LEAD_SLOW (LEAD_SLOW),
        .LEAD_FAST (LEAD_FAST),
        .CW        (CW)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .restart  (accept_w),
        .tick     (carrier_tick),
        .phase    (phase_w),
        .mode     (mode_w),
        .pcnt     (pcnt_w),
        .span_end (span_end_w)
    );

    ulm_wave_shaper #(.SLOW_UNIT(SLOW_UNIT), .CW(CW)) u_shape (
        .phase   (phase_w),
        .mode    (mode_w),
        .sym_bit (bit_w),
        .pcnt    (pcnt_w),
        .level   (mod_out)
    );

endmodule

// File: rtl/ulm_checker.sv
// Module: ulm_checker
// Temporal properties of the modulator, attached to the top by bind.
// Assumes: the bound signals come from the top-level scope.
module ulm_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       tick,
    input logic       start,
    input logic       busy,
    input logic       done,
    input logic       mod_out,
    input logic [1:0] phase,
    input logic [1:0] held_mode
);

    assert_idle_low_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mod_out);

    assert_done_on_fall_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);

    assert_done_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_done_after_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(busy));

    assert_lead_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == 2'd1) |-> mod_out);

    assert_mode_held_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(held_mode));

    assert_start_needed_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start));

    assert_tick_paced_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy) && !$past(tick)) |-> $stable(mod_out));

endmodule

bind uplink_load_modulator ulm_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (carrier_tick),
    .start     (start),
    .busy      (busy),
    .done      (done),
    .mod_out   (mod_out),
    .phase     (phase_w),
    .held_mode (mode_w)
);

// File: tb/uplink_load_modulator_tb.sv
// Scoreboard bench: the driver queues one expected level per carrier period.
// The monitor pops one entry per tick while busy.
module uplink_load_modulator_tb;

    localparam int FW = 16;
    localparam int NW = $clog2(FW + 1);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          carrier_tick = 1'b0;
    logic          start = 1'b0;
    logic [1:0]    mode = 2'd0;
    logic          sof_long = 1'b0;
    logic [NW-1:0] bit_count = '0;
    logic [FW-1:0] frame_word = '0;
    logic          mod_out, busy, done;

    int   checks = 0;
    int   failures = 0;
    int   done_seen = 0;
    logic prev_busy = 1'b0;
    logic exp_lvl[$];
    int   exp_tag[$];

    uplink_load_modulator #(.FRAME_W(FW)) u_dut (
        .clk (clk), .rst_n (rst_n), .carrier_tick (carrier_tick),
        .start (start), .mode (mode), .sof_long (sof_long),
        .bit_count (bit_count), .frame_word (frame_word),
        .mod_out (mod_out), .busy (busy), .done (done)
    );

    always #2 clk = ~clk;

    // Carrier tick on every other clock
    initial begin
        forever begin
            @(posedge clk); #1 carrier_tick = ~carrier_tick;
        end
    end

    function automatic string rtag(int t);
        case (t)
            3: return "R3";
            4: return "R4";
            5: return "R5";
            6: return "R6";
            7: return "R7";
            8: return "R8";
            9: return "R9";
            2: return "R2";
            default: return "R10";
        endcase
    endfunction

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic push_sym(input int m, input logic b, input int tag);
        int unit = (m == 1 || m == 3) ? 8 : 16;
        if (m <= 1) begin
            for (int p = 0; p < 4 * unit; p++) begin
                exp_lvl.push_back(b ? ((p < unit) || (p >= 2 * unit && p < 3 * unit)) : (p < 2 * unit));
                exp_tag.push_back(tag);
            end
        end else begin
            for (int p = 0; p < 2 * unit; p++) begin
                exp_lvl.push_back(b ? (p < unit) : (p >= unit));
                exp_tag.push_back(tag);
            end
        end
    endtask

    // Driver: queue expectations, pulse start, optionally disturb, wait for done
    task automatic send_frame(input int m, input logic sl, input int n,
                              input logic [FW-1:0] w, input int dtag, input logic disturb);
        int lead = (m == 1 || m == 3) ? 40 : 20;
        int neff = (n > FW) ? FW : n;
        int d0 = done_seen;
        for (int i = 0; i < lead; i++) begin exp_lvl.push_back(1'b1); exp_tag.push_back(3); end
        for (int i = 0; i < (sl ? 4 : 3); i++) push_sym(m, !(sl && i == 3), 4);
        for (int i = 0; i < neff; i++) push_sym(m, w[FW-1-i], dtag);
        @(posedge clk); #1;
        mode = 2'(m); sof_long = sl; bit_count = NW'(n); frame_word = w; start = 1'b1;
        @(posedge clk); #1 start = 1'b0;
        if (disturb) begin
            repeat (150) @(posedge clk);
            #1 mode = ~mode; sof_long = ~sof_long; frame_word = ~frame_word;
            bit_count = NW'(1); start = 1'b1;
            @(posedge clk); #1 start = 1'b0;
        end
        do @(negedge clk); while (!done);
        @(negedge clk);
        check("R11 one done per frame", done_seen - d0, 1);
        check({rtag(dtag), " expected periods left"}, exp_lvl.size(), 0);
        exp_lvl.delete(); exp_tag.delete();
    endtask

    // Monitor: compare per period, track busy/done relation
    always @(negedge clk) begin
        if (rst_n) begin
            if (carrier_tick && busy) begin
                if (exp_lvl.size() == 0) begin
                    check("R10 extra busy period", 1, 0);
                end else begin
                    check(rtag(exp_tag[0]), mod_out, exp_lvl[0]);
                    void'(exp_lvl.pop_front());
                    void'(exp_tag.pop_front());
                end
            end
            if (prev_busy && !busy) begin
                check("R11 done at busy fall", done, 1);
                check("R11 line low after frame", mod_out, 0);
                done_seen++;
            end else if (done) begin
                check("R11 stray done", done, 0);
            end
            prev_busy = busy;
        end
    end

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        start = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 busy in reset", busy, 0);
        check("R1 done in reset", done, 0);
        check("R1 line in reset", mod_out, 0);
        #1 start = 1'b0;
        @(posedge clk); #1 rst_n = 1'b1;
        @(negedge clk);
        check("R1 busy after reset", busy, 0);
        check("R1 line after reset", mod_out, 0);

        send_frame(0, 1'b0, 4,  16'hA000, 5, 1'b0);  // R5 slow anticollision
        send_frame(1, 1'b1, 5,  16'h6800, 6, 1'b0);  // R6 + R4 long start-of-frame
        send_frame(2, 1'b0, 8,  16'hB400, 7, 1'b0);  // R7 slow Manchester
        send_frame(3, 1'b1, 8,  16'h3C00, 8, 1'b0);  // R8 fast Manchester
        send_frame(0, 1'b1, 0,  16'hFFFF, 9, 1'b0);  // R9 no data bits
        send_frame(3, 1'b0, 20, 16'h8001, 9, 1'b0);  // R9 count clamped to width
        send_frame(2, 1'b0, 6,  16'h9C00, 2, 1'b1);  // R2 inputs and start ignored mid-frame
        send_frame(1, 1'b0, 16, 16'hFFFF, 6, 1'b0);  // R6 all ones
        send_frame(0, 1'b1, 3,  16'h0000, 5, 1'b0);  // R5 all zeros

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule